// File: doc/BRIEF.md
# Crosspoint Switch Control Front End

This block is the digital programming logic for a 16-input, 8-output analog crosspoint. Each of the eight outputs has a five-bit slot. Four bits of the slot pick the source input, and the fifth bit turns on that output's buffer. All eight slots together form a 40-bit staging register. Software fills that register in one of two ways. It can shift in the whole array one bit per falling clock edge. It can also write one slot at a time through a parallel port that names the slot with a 3-bit address.

A second 40-bit register carries the live connection map. It follows the staging register while both the update strobe and the chip enable are low. It freezes when either one goes high. This lets a new map be staged while the old one keeps routing, and then applied all at once.

The live map drives a decoder for each output. The eight decoders produce 128 one-hot switch enables and eight buffer enables. The last bit of the staging chain appears on a serial output, so several devices can be cascaded. An active-low reset turns every output off and clears both registers.

Top module: `xpt_ctrl`

## Requirements
- R1: Slot k sits in register bits [5k+4:5k]. Bits [5k+3:5k] are the input select, with bit 5k as its LSB. Bit 5k+4 is the buffer enable. Switch enable `sw_en[16k+i]` connects input i to output k.
- R2: With `par_mode` low and `ce_n` low, each falling clock edge shifts `sdi` into bit 0 and moves every bit up one place. The first of 40 bits therefore lands in bit 39 (output 7 enable), and the last lands in bit 0 (output 0 select LSB).
- R3: `sdo` always shows staging bit 39, so after each shift it carries the bit that was previously at bit 38.
- R4: With `par_mode` high and `ce_n` low, a falling edge writes `pdata` into the slot chosen by `addr` (bit 0 is the LSB). All other slots keep their contents.
- R5: While `ce_n` is high, falling clock edges leave the staging register and the live map unchanged.
- R6: The live map follows the staging register while `upd_n` and `ce_n` are both low. It holds its last value otherwise.
- R7: An enabled output drives exactly one of its 16 switch enables high: the one its select names. Its `out_en` bit is high.
- R8: A disabled output drives all 16 of its switch enables low, and its `out_en` bit is low.
- R9: While `rst_n` is low, every `sw_en` and `out_en` bit is low, without waiting for a clock. Reset clears both registers, so the outputs stay off after release until new data is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Programming clock, captured on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, forces all outputs off |
| ce_n | input | 1 | Active-low chip enable for loading and latching |
| upd_n | input | 1 | Active-low update: low passes staging to live map, high holds |
| par_mode | input | 1 | Low selects serial loading, high selects parallel slot writes |
| sdi | input | 1 | Serial data in |
| addr | input | 3 | Slot address for parallel writes |
| pdata | input | 5 | Parallel slot data: enable in bit 4, select in bits 3:0 |
| sdo | output | 1 | Serial data out, last stage of the chain |
| sw_en | output | 128 | One-hot switch enables, 16 per output |
| out_en | output | 8 | Output buffer enables |

## Verification
The staging register has no direct view. It can be seen only through `sdo`, or by reopening the update path. The most awkward case to reach is proving that a frozen live map hides a staged pattern while that staged pattern still reaches the chain. The bench holds `upd_n` high and loads a new array, then confirms the outputs have not moved. Next it shifts 40 zeros and compares every bit leaving `sdo` with the order it was sent in. Finally it drops `upd_n` and checks that the now-empty staging register shows up immediately. The chip-enable test uses the same reopening trick to show that gated clocks left the staging register untouched.

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 8,
  localparam int SEL_W  = $clog2(N_IN),
  localparam int SLOT_W = SEL_W + 1,
  localparam int ADDR_W = $clog2(N_OUT),
  localparam int TOT    = N_OUT * SLOT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   upd_n,
  input  logic                   par_mode,
  input  logic                   sdi,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [SLOT_W-1:0]      pdata,
  output logic                   sdo,
  output logic [N_OUT*N_IN-1:0]  sw_en,
  output logic [N_OUT-1:0]       out_en
);

  logic [TOT-1:0] stage_q, stage_nx, live_q, map;
  logic           load, open;

  assign load = !ce_n;
  assign open = !ce_n && !upd_n;

  always_comb begin
    stage_nx = stage_q;
    if (load) begin
      if (par_mode) stage_nx[addr*SLOT_W +: SLOT_W] = pdata;
      else          stage_nx = {stage_q[TOT-2:0], sdi};
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q  <= '0;
    end else begin
      stage_q <= stage_nx;
      if (open) live_q <= stage_nx;
    end
  end

  assign map = open ? stage_q : live_q;
  assign sdo = stage_q[TOT-1];

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign out_en[k] = rst_n && map[k*SLOT_W+SEL_W];
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign sw_en[k*N_IN+i] = out_en[k] && (map[k*SLOT_W +: SEL_W] == SEL_W'(i));
    end

    // R7 R8
    onehot_slot_chk: assert property (@(posedge clk)
      $onehot0(sw_en[k*N_IN +: N_IN]) && (out_en[k] == (sw_en[k*N_IN +: N_IN] != '0)));

    // R4
    par_keep_chk: assert property (@(negedge clk) disable iff (!rst_n)
      (!ce_n && par_mode && addr != ADDR_W'(k)) |=> $stable(stage_q[k*SLOT_W +: SLOT_W]));
  end

  // R9
  reset_off_chk: assert property (@(posedge clk)
    !rst_n |-> (sw_en == '0 && out_en == '0));

  // R3
  chain_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!ce_n && !par_mode) |=> sdo == $past(stage_q[TOT-2]));

  // R5
  ce_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ce_n |=> ($stable(stage_q) && $stable(live_q)));

  // R6
  upd_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    upd_n |=> $stable(live_q));

endmodule

// File: tb/xpt_ctrl_test.sv
module xpt_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ce_n, upd_n, par_mode, sdi, sdo;
  logic [2:0] addr;
  logic [4:0] pdata;
  logic [127:0] sw_en;
  logic [7:0] out_en;

  xpt_ctrl uut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .upd_n(upd_n),
    .par_mode(par_mode), .sdi(sdi), .addr(addr), .pdata(pdata),
    .sdo(sdo), .sw_en(sw_en), .out_en(out_en));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] ps[8], es[8];
  logic pe[8], ee[8];
  logic seq[40];

  function automatic logic [135:0] expv();
    logic [135:0] v = '0;
    for (int k = 0; k < 8; k++) begin
      if (ee[k]) v[k*16 + int'(es[k])] = 1'b1;
      v[128+k] = ee[k];
    end
    return v;
  endfunction

  task automatic chk(string r, logic [135:0] act, logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic chk_map(string r);
    chk(r, {out_en, sw_en}, expv());
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic latch_all();
    for (int k = 0; k < 8; k++) begin es[k] = ps[k]; ee[k] = pe[k]; end
  endtask

  task automatic ser_load();
    int n = 0;
    par_mode = 0; ce_n = 0;
    for (int k = 7; k >= 0; k--)
      for (int b = 4; b >= 0; b--) begin
        sdi = (b == 4) ? pe[k] : ps[k][b];
        seq[n] = sdi; n++;
        step();
      end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; upd_n = 0; par_mode = 0; sdi = 0; addr = '0; pdata = '0;
    for (int k = 0; k < 8; k++) begin ps[k] = 0; pe[k] = 0; end
    latch_all();
    step(); step();
    chk_map("R9 reset state");
    chk("R9 sdo after reset", {135'd0, sdo}, 136'd0);
    rst_n = 1; step();
    chk_map("R9 off after release");

    // R1 R2 R7: serial sweep over every select value on every output
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 8; k++) begin ps[k] = 4'((s + k) % 16); pe[k] = 1; end
      upd_n = 0; ser_load(); latch_all();
      chk_map("R2 R7 R1 serial sweep");
    end

    // R8: alternate outputs disabled
    for (int k = 0; k < 8; k++) begin ps[k] = 4'(15 - 2*k); pe[k] = k[0]; end
    ser_load(); latch_all();
    chk_map("R8 disabled outputs");

    // R6 hold while staging a new map
    upd_n = 1;
    for (int k = 0; k < 8; k++) begin ps[k] = 4'(3*k + 1); pe[k] = !k[0]; end
    ser_load();
    chk_map("R6 hold with upd_n high");

    // R3: drain the chain and compare with the send order
    sdi = 0;
    chk("R3 sdo before drain", {135'd0, sdo}, {135'd0, seq[0]});
    for (int j = 1; j < 40; j++) begin
      step();
      chk("R3 sdo chain", {135'd0, sdo}, {135'd0, seq[j]});
    end
    step();
    for (int k = 0; k < 8; k++) begin ps[k] = 0; pe[k] = 0; end
    chk_map("R6 hold after drain");
    upd_n = 0; #1;
    latch_all();
    chk_map("R6 transparent on upd_n low");

    // R5: chip enable high blocks loads
    for (int k = 0; k < 8; k++) begin ps[k] = 4'(k + 8); pe[k] = 1; end
    ser_load(); latch_all();
    ce_n = 1; sdi = 1; par_mode = 0;
    for (int j = 0; j < 6; j++) begin sdi = ~sdi; step(); end
    par_mode = 1; addr = 3'd2; pdata = 5'h00;
    for (int j = 0; j < 4; j++) step();
    chk_map("R5 live map untouched");
    ce_n = 0; par_mode = 0; #1;
    chk_map("R5 staging untouched");

    // R4: exhaustive parallel writes
    par_mode = 1; ce_n = 0; upd_n = 0;
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 32; d++) begin
        addr = 3'(a); pdata = 5'(d);
        step();
        ps[a] = pdata[3:0]; pe[a] = pdata[4];
        latch_all();
        chk_map("R4 R1 parallel slot write");
      end

    // R9 asynchronous mid-run reset
    for (int k = 0; k < 8; k++) begin ps[k] = 4'(k); pe[k] = 1; end
    for (int a = 0; a < 8; a++) begin addr = 3'(a); pdata = {1'b1, 4'(a)}; step(); end
    latch_all();
    chk_map("R4 preload before reset");
    #2 rst_n = 0; #1;
    for (int k = 0; k < 8; k++) begin ps[k] = 0; pe[k] = 0; end
    latch_all();
    chk_map("R9 async off");
    step(); rst_n = 1; ce_n = 1; step();
    chk_map("R9 cleared after release");
    ce_n = 0; #1;
    chk_map("R9 staging cleared");
    addr = 3'd5; pdata = 5'h1c; step();
    ps[5] = 4'hc; pe[5] = 1; latch_all();
    chk_map("R4 write after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule